// File: doc/BRIEF.md
# Single-Wire Byte Link with Sync Pulse and Parity

This block moves one byte at a time across a single shared wire that a pull-up holds high when nobody drives it. The transmitter frames every byte as a low sync slot, a high mark slot, eight data bits sent most-significant bit first, and one even-parity bit. Every slot lasts exactly `CLK_PER_BIT` clock cycles. After the parity slot it keeps driving the wire low (parked), so the next frame again produces a clean rising edge at the end of its sync slot. A separate release strobe gives the wire back to the pull-up.

The receiver is armed per byte. It first waits a bounded time for the wire to be low. If the wire never goes low in that window, it gives up waiting and carries on. It then waits with no limit for the wire to go high and aligns on that rising edge. It skips the mark slot, then samples each data bit and the parity bit half a slot into the slot. A parity mismatch is flagged with the byte and counted in a saturating error counter. Software clears that counter before a multi-byte transfer and reads it as zero afterwards when every byte arrived intact.

The pin is modelled as three signals: a drive value, an output enable and a sensed input. The sensed input passes through a two-flop synchronizer. Byte sequencing, direction changes and transaction control belong to the logic around this block.

Top module: `swire_byte_link`

## Requirements
- R1: After synchronous reset the wire is released (`pin_oe`=0), `tx_busy`, `rx_busy` and `rx_valid` are 0, and `err_count` is 0.
- R2: A `tx_start` accepted while the transmitter is idle or parked drives the wire with `pin_oe`=1 through slots of exactly `CLK_PER_BIT` cycles each, in this order: slot 0 low (sync), slot 1 high (mark), then slots 2..9 carrying data bits 7 down to 0.
- R3: Slot 10 carries even parity: its level is the XOR of the eight data bits (1 when the byte has an odd number of ones).
- R4: When slot 10 ends, `tx_done` pulses for one cycle, `tx_busy` falls, and the wire stays driven low (`pin_oe`=1, `pin_out`=0) until the next accepted `tx_start`. A `tx_release` while parked sets `pin_oe` to 0 on the next cycle.
- R5: `tx_start` while `tx_busy` is 1 is ignored: the frame in flight and its data are unchanged.
- R6: An armed receiver aligns on the first rising edge of the synchronized wire, skips one slot, and samples nine bits, each `CLK_PER_BIT/2` cycles into its slot followed by the remaining `CLK_PER_BIT - CLK_PER_BIT/2` cycles. It presents the first eight samples as `rx_byte` (first sample in bit 7) with a one-cycle `rx_valid`.
- R7: If the wire is not seen low within `WAIT_MULT*CLK_PER_BIT` cycles of arming, the receiver stops waiting for low and proceeds. On an idle-high wire it returns 8'hFF with `rx_perr`=1, and `rx_valid` does not occur within those first `WAIT_MULT*CLK_PER_BIT` cycles.
- R8: The wait for the rising edge has no limit: a sync low longer than the bounded window is still received correctly.
- R9: When the sampled parity bit differs from the XOR of the sampled data bits, `rx_perr`=1 with that `rx_valid`, and `err_count` increments in the same cycle `rx_valid` is high.
- R10: `err_count` saturates at 2^`ERR_W`-1. `err_clr` sets it to 0 on the next cycle and takes precedence over an increment.
- R11: `rx_arm` while `rx_busy` is 1 is ignored: the reception in progress completes with one `rx_valid` and the correct byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_data | input | DATA_W | Byte to send, captured with an accepted `tx_start` |
| tx_start | input | 1 | Start a frame (accepted when idle or parked) |
| tx_release | input | 1 | Release a parked wire to the pull-up |
| tx_busy | output | 1 | Frame in progress |
| tx_done | output | 1 | One-cycle pulse when the parity slot ends |
| rx_arm | input | 1 | Arm the receiver for one byte |
| rx_busy | output | 1 | Receiver armed or receiving |
| rx_byte | output | DATA_W | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_byte` and `rx_perr` |
| rx_perr | output | 1 | Parity mismatch on the last received byte |
| err_clr | input | 1 | Clear the parity error counter |
| err_count | output | ERR_W | Saturating parity error count |
| pin_out | output | 1 | Wire drive value |
| pin_oe | output | 1 | Wire drive enable |
| pin_in | input | 1 | Sensed wire level (asynchronous) |

## Verification
The assertions take for granted that the far end uses the same slot length, and that nothing else drives the wire while `pin_oe` is 1. Under these conditions a park, a done pulse and an error increment line up with the port behaviour they check. The bench keeps to this. It models the wire as the block's drive when enabled, else an optional bench driver, else the pull-up. The bench driver only acts while the block has released the wire, and its slots are exactly `CLK_PER_BIT` cycles. An odd slot length of 9 exercises the unequal half-slot split. A 2-bit counter makes saturation reachable in four bad bytes.

// File: rtl/swl_pkg.sv
// Shared state encodings for the single-wire byte link.
package swl_pkg;

    // Transmitter: released wire, frame in flight, wire parked low.
    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_SLOT = 2'd1,
        TX_PARK = 2'd2
    } tx_state_t;

    // Receiver: idle, bounded low search, unbounded high search,
    // mark slot skip, first half of a bit slot, second half of a bit slot.
    typedef enum logic [2:0] {
        RX_IDLE      = 3'd0,
        RX_SEEK_LOW  = 3'd1,
        RX_SEEK_HIGH = 3'd2,
        RX_MARK      = 3'd3,
        RX_HALF_A    = 3'd4,
        RX_HALF_B    = 3'd5
    } rx_state_t;

endpackage

// File: rtl/swl_sync2.sv
// Two-flop synchronizer for the sensed wire level.
// Assumes: the input is asynchronous; the reset value matches the idle
// wire level so no false edge is seen when reset ends.
module swl_sync2 #(
    parameter bit RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic meta_q;
    logic stable_q;

    // Shift the asynchronous level through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q   <= RST_VAL;
            stable_q <= RST_VAL;
        end else begin
            meta_q   <= async_i;
            stable_q <= meta_q;
        end
    end

    assign sync_o = stable_q;

endmodule

// File: rtl/swl_tx.sv
// Frame transmitter: sync low slot, mark high slot, data MSB first, even
// parity, then the wire is parked low until the next start or a release.
// Assumes: CLK_PER_BIT >= 2 and DATA_W >= 1.
module swl_tx
    import swl_pkg::*;
#(
    parameter int CLK_PER_BIT = 750,
    parameter int DATA_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] data_i,
    input  logic              start_i,
    input  logic              release_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              pin_out_o,
    output logic              pin_oe_o
);

    localparam int NSLOT  = DATA_W + 3;
    localparam int CNT_W  = $clog2(CLK_PER_BIT);
    localparam int SLOT_W = $clog2(NSLOT);
    localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(CLK_PER_BIT - 1);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(NSLOT - 1);

    tx_state_t          state_q;
    logic [NSLOT-1:0]   frame_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [SLOT_W-1:0]  slot_q;
    logic               done_q;
    logic [NSLOT-1:0]   frame_load;

    // Build the slot levels of a whole frame, first slot in the top bit.
    always_comb begin
        frame_load = {1'b0, 1'b1, data_i, ^data_i};
    end

    // Slot timing, frame shifting and the parked/released wire state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            frame_q <= '0;
            cnt_q   <= '0;
            slot_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                TX_IDLE, TX_PARK: begin
                    if (start_i) begin
                        state_q <= TX_SLOT;
                        frame_q <= frame_load;
                        cnt_q   <= '0;
                        slot_q  <= '0;
                    end else if (release_i && (state_q == TX_PARK)) begin
                        state_q <= TX_IDLE;
                    end
                end
                TX_SLOT: begin
                    if (cnt_q == CNT_LAST) begin
                        cnt_q <= '0;
                        if (slot_q == SLOT_LAST) begin
                            state_q <= TX_PARK;
                            done_q  <= 1'b1;
                        end else begin
                            slot_q  <= slot_q + 1'b1;
                            frame_q <= {frame_q[NSLOT-2:0], 1'b0};
                        end
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= TX_IDLE;
            endcase
        end
    end

    // Drive the wire from the head of the frame; park low; release idle.
    always_comb begin
        busy_o    = (state_q == TX_SLOT);
        pin_oe_o  = (state_q != TX_IDLE);
        pin_out_o = (state_q == TX_SLOT) && frame_q[NSLOT-1];
        done_o    = done_q;
    end

endmodule

// File: rtl/swl_rx.sv
// Byte receiver: bounded wait for a low wire, unbounded wait for the
// rising edge, one mark slot skipped, then DATA_W data bits and a parity
// bit sampled half a slot into each slot.
// Assumes: line_i is already synchronized; CLK_PER_BIT >= 2, DATA_W >= 2.
module swl_rx
    import swl_pkg::*;
#(
    parameter int CLK_PER_BIT = 750,
    parameter int DATA_W      = 8,
    parameter int WAIT_MULT   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_i,
    input  logic              line_i,
    output logic              busy_o,
    output logic [DATA_W-1:0] byte_o,
    output logic              valid_o,
    output logic              perr_o,
    output logic              err_evt_o
);

    localparam int HALF1    = CLK_PER_BIT / 2;
    localparam int HALF2    = CLK_PER_BIT - HALF1;
    localparam int WAIT_LIM = WAIT_MULT * CLK_PER_BIT;
    localparam int NBITS    = DATA_W + 1;
    localparam int CNT_W    = $clog2(WAIT_LIM + 1);
    localparam int BIDX_W   = $clog2(NBITS + 1);
    localparam logic [CNT_W-1:0]  WAIT_LAST = CNT_W'(WAIT_LIM - 1);
    localparam logic [CNT_W-1:0]  SLOT_LAST = CNT_W'(CLK_PER_BIT - 1);
    localparam logic [CNT_W-1:0]  H1_LAST   = CNT_W'(HALF1 - 1);
    localparam logic [CNT_W-1:0]  H2_LAST   = CNT_W'(HALF2 - 1);
    localparam logic [BIDX_W-1:0] BIDX_PAR  = BIDX_W'(DATA_W);

    rx_state_t          state_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [BIDX_W-1:0]  bidx_q;
    logic [DATA_W-1:0]  shift_q;
    logic               par_acc_q;
    logic               par_bit_q;
    logic [DATA_W-1:0]  byte_q;
    logic               valid_q;
    logic               perr_q;
    logic               finish;
    logic               mismatch;

    // Last cycle of the parity slot, and its parity verdict.
    always_comb begin
        finish   = (state_q == RX_HALF_B) && (cnt_q == H2_LAST) && (bidx_q == BIDX_PAR);
        mismatch = par_acc_q ^ par_bit_q;
    end

    // Alignment, half-slot timing and bit capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= RX_IDLE;
            cnt_q     <= '0;
            bidx_q    <= '0;
            shift_q   <= '0;
            par_acc_q <= 1'b0;
            par_bit_q <= 1'b0;
        end else begin
            case (state_q)
                RX_IDLE: begin
                    if (arm_i) begin
                        state_q <= RX_SEEK_LOW;
                        cnt_q   <= '0;
                    end
                end
                RX_SEEK_LOW: begin
                    if (!line_i || (cnt_q == WAIT_LAST)) begin
                        state_q <= RX_SEEK_HIGH;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                RX_SEEK_HIGH: begin
                    if (line_i) begin
                        state_q <= RX_MARK;
                        cnt_q   <= '0;
                    end
                end
                RX_MARK: begin
                    if (cnt_q == SLOT_LAST) begin
                        state_q   <= RX_HALF_A;
                        cnt_q     <= '0;
                        bidx_q    <= '0;
                        par_acc_q <= 1'b0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                RX_HALF_A: begin
                    if (cnt_q == H1_LAST) begin
                        state_q <= RX_HALF_B;
                        cnt_q   <= '0;
                        if (bidx_q == BIDX_PAR) begin
                            par_bit_q <= line_i;
                        end else begin
                            shift_q   <= {shift_q[DATA_W-2:0], line_i};
                            par_acc_q <= par_acc_q ^ line_i;
                        end
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                RX_HALF_B: begin
                    if (cnt_q == H2_LAST) begin
                        cnt_q <= '0;
                        if (bidx_q == BIDX_PAR) begin
                            state_q <= RX_IDLE;
                        end else begin
                            state_q <= RX_HALF_A;
                            bidx_q  <= bidx_q + 1'b1;
                        end
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= RX_IDLE;
            endcase
        end
    end

    // Present the byte and its parity verdict with a one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_q  <= '0;
            valid_q <= 1'b0;
            perr_q  <= 1'b0;
        end else begin
            valid_q <= finish;
            if (finish) begin
                byte_q <= shift_q;
                perr_q <= mismatch;
            end
        end
    end

    assign busy_o    = (state_q != RX_IDLE);
    assign byte_o    = byte_q;
    assign valid_o   = valid_q;
    assign perr_o    = perr_q;
    assign err_evt_o = finish && mismatch;

endmodule

// File: rtl/swl_errcnt.sv
// Saturating parity error counter with a clear that wins over a count.
// Assumes: inc_i is a single-cycle event per received byte.
module swl_errcnt #(
    parameter int ERR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [ERR_W-1:0] count_o
);

    localparam logic [ERR_W-1:0] SAT = '1;

    logic [ERR_W-1:0] count_q;

    // Clear, else count up to the saturation value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clr_i) begin
            count_q <= '0;
        end else if (inc_i && (count_q != SAT)) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign count_o = count_q;

endmodule

// File: rtl/swire_byte_link.sv
// Single-wire byte link: transmitter, receiver, input synchronizer and
// parity error counter around one open-drain style pin.
// Assumes: the wire idles high through a pull-up; both ends share
// CLK_PER_BIT; direction changes are sequenced outside this block.
module swire_byte_link #(
    parameter int CLK_PER_BIT = 750,
    parameter int DATA_W      = 8,
    parameter int WAIT_MULT   = 5,
    parameter int ERR_W       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_start,
    input  logic              tx_release,
    output logic              tx_busy,
    output logic              tx_done,
    input  logic              rx_arm,
    output logic              rx_busy,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_valid,
    output logic              rx_perr,
    input  logic              err_clr,
    output logic [ERR_W-1:0]  err_count,
    output logic              pin_out,
    output logic              pin_oe,
    input  logic              pin_in
);

    logic line_s;
    logic err_evt;

    swl_sync2 #(
        .RST_VAL(1'b1)
    ) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(pin_in),
        .sync_o (line_s)
    );

    swl_tx #(
        .CLK_PER_BIT(CLK_PER_BIT),
        .DATA_W     (DATA_W)
    ) i_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .data_i   (tx_data),
        .start_i  (tx_start),
        .release_i(tx_release),
        .busy_o   (tx_busy),
        .done_o   (tx_done),
        .pin_out_o(pin_out),
        .pin_oe_o (pin_oe)
    );

    swl_rx #(
        .CLK_PER_BIT(CLK_PER_BIT),
        .DATA_W     (DATA_W),
        .WAIT_MULT  (WAIT_MULT)
    ) i_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm_i    (rx_arm),
        .line_i   (line_s),
        .busy_o   (rx_busy),
        .byte_o   (rx_byte),
        .valid_o  (rx_valid),
        .perr_o   (rx_perr),
        .err_evt_o(err_evt)
    );

    swl_errcnt #(
        .ERR_W(ERR_W)
    ) i_err (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (err_clr),
        .inc_i  (err_evt),
        .count_o(err_count)
    );

endmodule

// File: rtl/swl_checker.sv
// Port-level properties of the single-wire byte link, bound to the top.
module swl_checker #(
    parameter int ERR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_start,
    input logic             tx_release,
    input logic             tx_busy,
    input logic             tx_done,
    input logic             rx_busy,
    input logic             rx_valid,
    input logic             rx_perr,
    input logic             err_clr,
    input logic [ERR_W-1:0] err_count,
    input logic             pin_out,
    input logic             pin_oe
);

    localparam logic [ERR_W-1:0] SAT = '1;

    // R2
    frame_opens_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> (pin_oe && !pin_out));

    // R5
    start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> $past(tx_start));

    // R4
    done_parks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> (pin_oe && !pin_out && !tx_busy));

    // R4
    park_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe && !tx_busy && !tx_start && !tx_release) |=> (pin_oe && !pin_out));

    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R6
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> !rx_busy);

    // R9
    count_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(err_count) |-> ($past(err_clr) || (rx_valid && rx_perr)));

    // R10
    count_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((err_count == SAT) && !err_clr) |=> (err_count == SAT));

    // R10
    count_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr |=> (err_count == '0));

endmodule

bind swire_byte_link swl_checker #(
    .ERR_W(ERR_W)
) i_swl_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_start  (tx_start),
    .tx_release(tx_release),
    .tx_busy   (tx_busy),
    .tx_done   (tx_done),
    .rx_busy   (rx_busy),
    .rx_valid  (rx_valid),
    .rx_perr   (rx_perr),
    .err_clr   (err_clr),
    .err_count (err_count),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
);

// File: tb/test_swire_byte_link.sv
// Bench: loopback sweep of all byte values plus bench-driven receive cases.
module test_swire_byte_link;

    localparam int P     = 9;
    localparam int DW    = 8;
    localparam int WM    = 5;
    localparam int EW    = 2;
    localparam int HALF1 = P / 2;
    localparam int NSL   = DW + 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] tx_data = '0;
    logic          tx_start = 1'b0;
    logic          tx_release = 1'b0;
    logic          tx_busy;
    logic          tx_done;
    logic          rx_arm = 1'b0;
    logic          rx_busy;
    logic [DW-1:0] rx_byte;
    logic          rx_valid;
    logic          rx_perr;
    logic          err_clr = 1'b0;
    logic [EW-1:0] err_count;
    logic          pin_out;
    logic          pin_oe;
    logic          pin_in;
    logic          bfm_oe = 1'b0;
    logic          bfm_val = 1'b1;

    always #4 clk = ~clk;

    // Wire model: block drive, else bench drive, else pull-up.
    assign pin_in = pin_oe ? pin_out : (bfm_oe ? bfm_val : 1'b1);

    swire_byte_link #(
        .CLK_PER_BIT(P),
        .DATA_W     (DW),
        .WAIT_MULT  (WM),
        .ERR_W      (EW)
    ) i_swire_byte_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_data   (tx_data),
        .tx_start  (tx_start),
        .tx_release(tx_release),
        .tx_busy   (tx_busy),
        .tx_done   (tx_done),
        .rx_arm    (rx_arm),
        .rx_busy   (rx_busy),
        .rx_byte   (rx_byte),
        .rx_valid  (rx_valid),
        .rx_perr   (rx_perr),
        .err_clr   (err_clr),
        .err_count (err_count),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .pin_in    (pin_in)
    );

    int checks = 0;
    int errors = 0;
    int n_valid = 0;
    logic [DW-1:0] last_byte = '0;
    logic          last_perr = 1'b0;
    logic [EW-1:0] last_cnt = '0;

    // Record each receive strobe with the counter value seen alongside it.
    always @(posedge clk) begin
        if (rst_n && rx_valid) begin
            n_valid   <= n_valid + 1;
            last_byte <= rx_byte;
            last_perr <= rx_perr;
            last_cnt  <= err_count;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Expected wire level in slot s of a frame carrying d.
    function automatic logic exp_slot(input logic [DW-1:0] d, input int s);
        if (s == 0) return 1'b0;
        if (s == 1) return 1'b1;
        if (s <= DW + 1) return d[DW + 1 - s];
        return ^d;
    endfunction

    // Send d in loopback, check every slot centre, the park and the echo.
    task automatic tx_loop(input logic [DW-1:0] d, input bit inject);
        int bad;
        int n0;
        bad = 0;
        @(negedge clk);
        tx_data  = d;
        tx_start = 1'b1;
        rx_arm   = 1'b1;
        @(negedge clk);
        tx_start = 1'b0;
        rx_arm   = 1'b0;
        n0 = n_valid;
        for (int n = 0; n < NSL * P; n++) begin
            if ((n % P) == HALF1) begin
                if (pin_oe !== 1'b1 || pin_out !== exp_slot(d, n / P)) bad++;
            end
            if (inject && n == 3 * P) begin
                tx_data  = ~d;
                tx_start = 1'b1;
            end
            if (inject && n == 3 * P + 1) begin
                tx_start = 1'b0;
                tx_data  = d;
            end
            @(negedge clk);
        end
        if (inject) chk("R5", "frame with start while busy, bad slots", bad, 0);
        else        chk("R2/R3", "frame slot mismatches", bad, 0);
        chk("R4", "tx_done at end of parity slot", int'(tx_done), 1);
        chk("R4", "parked oe/out/busy", int'({pin_oe, pin_out, tx_busy}), 3'b100);
        for (int w = 0; w < 3 * P; w++) begin
            if (n_valid != n0) break;
            @(negedge clk);
        end
        chk("R6", "loopback strobes", n_valid - n0, 1);
        chk("R6", "loopback byte", int'(last_byte), int'(d));
        chk("R3", "loopback parity flag", int'(last_perr), 0);
    endtask

    // Bench drives one frame; low_len is the sync low length in cycles.
    task automatic bfm_frame(input logic [DW-1:0] d, input bit bad_par,
                             input int low_len, input bit extra_arm, input string req);
        int n0;
        @(negedge clk);
        rx_arm  = 1'b1;
        bfm_oe  = 1'b1;
        bfm_val = 1'b0;
        @(negedge clk);
        rx_arm = 1'b0;
        n0 = n_valid;
        repeat (low_len - 1) @(negedge clk);
        bfm_val = 1'b1;
        repeat (P) @(negedge clk);
        for (int i = DW - 1; i >= 0; i--) begin
            bfm_val = d[i];
            if (extra_arm && i == 4) begin
                rx_arm = 1'b1;
                @(negedge clk);
                rx_arm = 1'b0;
                repeat (P - 1) @(negedge clk);
            end else begin
                repeat (P) @(negedge clk);
            end
        end
        bfm_val = (^d) ^ bad_par;
        repeat (P) @(negedge clk);
        bfm_val = 1'b0;
        repeat (P) @(negedge clk);
        bfm_oe  = 1'b0;
        bfm_val = 1'b1;
        repeat (2) @(negedge clk);
        chk(req, "bench frame strobes", n_valid - n0, 1);
        chk(req, "bench frame byte", int'(last_byte), int'(d));
        chk(req, "bench frame parity flag", int'(last_perr), int'(bad_par));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "in reset oe/busy/valid/count",
            int'({pin_oe, tx_busy, rx_busy, rx_valid, err_count}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", "after reset oe/busy/valid/count",
            int'({pin_oe, tx_busy, rx_busy, rx_valid, err_count}), 0);
        chk("R1", "released wire level", int'(pin_in), 1);

        // R2 R3 R6: every byte value, back to back from the parked wire.
        for (int v = 0; v < 256; v++) begin
            tx_loop(DW'(v), 1'b0);
        end

        // R5: a second start mid-frame changes nothing.
        tx_loop(8'h6B, 1'b1);

        // R4: release the parked wire.
        @(negedge clk);
        chk("R4", "done lasts one cycle", int'(tx_done), 0);
        tx_release = 1'b1;
        @(negedge clk);
        tx_release = 1'b0;
        chk("R4", "oe after release", int'(pin_oe), 0);
        chk("R4", "wire after release", int'(pin_in), 1);

        // R9 R10: four bad-parity frames saturate a 2-bit counter.
        for (int k = 1; k <= 4; k++) begin
            bfm_frame(8'hA5, 1'b1, P, 1'b0, "R9");
            chk("R9", "count in the strobe cycle", int'(last_cnt), (k < 3) ? k : 3);
            chk("R10", "count after frame", int'(err_count), (k < 3) ? k : 3);
        end
        @(negedge clk);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        chk("R10", "count after clear", int'(err_count), 0);

        // R11: arm pulse mid-reception ignored.
        bfm_frame(8'hC3, 1'b0, P, 1'b1, "R11");
        chk("R11", "count after good frame", int'(err_count), 0);

        // R8: sync low far longer than the bounded window.
        bfm_frame(8'h3C, 1'b0, 10 * P, 1'b0, "R8");

        // R7: arm on an idle-high wire.
        begin
            int n0;
            int early;
            @(negedge clk);
            rx_arm = 1'b1;
            @(negedge clk);
            rx_arm = 1'b0;
            n0 = n_valid;
            early = 0;
            for (int n = 0; n < WM * P; n++) begin
                if (n_valid != n0) early = 1;
                @(negedge clk);
            end
            chk("R7", "strobe inside the low-wait window", early, 0);
            for (int n = 0; n < 12 * P; n++) begin
                if (n_valid != n0) break;
                @(negedge clk);
            end
            chk("R7", "strobes after timeout", n_valid - n0, 1);
            chk("R7", "idle-high byte", int'(last_byte), 8'hFF);
            chk("R7", "idle-high parity flag", int'(last_perr), 1);
            chk("R9", "count after idle-high frame", int'(err_count), 1);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule